// File: doc/BRIEF.md
# Burst Address Generator

This block sits in front of one port of a memory array and decides which word that port touches in each clock cycle. Every cycle it samples an external address bus and three active-low controls: a clear, a strobe and a count enable. It returns the access address for the current cycle as a combinational output. It also keeps a stored pointer that the next cycle can continue from.

The clear always wins and sends the port to word zero. The strobe comes next: it takes the external address and uses it. The count enable comes last: it steps to the word after the stored pointer. With all three controls high, the port stays on its stored word. In each cycle the address used for the access is the value written into the pointer at the next edge. A sequence of strobe, step, step therefore visits A, A+1, A+2. Stepping past the last word of the array wraps to word zero. The block has no chip-select input, so it keeps running while the port is idle.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, the pointer is cleared at each clock edge, whatever the controls are doing. After reset the stored pointer `ptr_now` reads 0.
- R2: When `clr_n` is 0, `acc_addr` is 0 in that cycle and `ptr_now` is 0 after the edge. The levels of `strobe_n` and `step_n` have no effect.
- R3: When `clr_n` is 1 and `strobe_n` is 0, `acc_addr` equals `ext_addr` in that cycle and `ptr_now` takes that value at the edge. The level of `step_n` has no effect.
- R4: When `clr_n` and `strobe_n` are 1 and `step_n` is 0, `acc_addr` is the stored pointer plus one and `ptr_now` takes that value at the edge.
- R5: When all three controls are 1, `acc_addr` equals the stored pointer, `ptr_now` does not change, and `ext_addr` has no effect.
- R6: A step from the last word, 2^ADDR_W-1, gives word 0.
- R7: A burst that starts with a strobe at address A visits A, A+1, A+2 in successive step cycles. Hold cycles pause the burst without skipping a word. A clear cycle accesses word 0, and the step that follows it accesses word 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| ext_addr | input | ADDR_W | External word address |
| strobe_n | input | 1 | Active-low: use and capture `ext_addr` |
| step_n | input | 1 | Active-low: advance to the next word |
| clr_n | input | 1 | Active-low: go to word zero; highest priority |
| acc_addr | output | ADDR_W | Word address for this cycle's access |
| ptr_now | output | ADDR_W | Stored pointer as of the last edge |

## Verification
The hardest case to reach from the ports is the wrap from the top word. A plain count from zero would take 2^ADDR_W steps to get there. The stimulus instead strobes in the word just below the top, then steps twice and holds in between. A second hard area is the set of cycles in which two or three controls are low together. The stimulus drives every priority clash on purpose and changes `ext_addr` during hold and clear cycles. This shows that the losing inputs leave no trace on `acc_addr` or `ptr_now`.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        MODE_KEEP  = 2'd0,
        MODE_STEP  = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } bag_mode_e;
endpackage

// File: rtl/bag_decode.sv
module bag_decode
    import bag_pkg::*;
(
    input  logic      strobe_n,
    input  logic      step_n,
    input  logic      clr_n,
    output bag_mode_e mode
);
    // Fixed priority: clear, then strobe, then step, else keep.
    always_comb begin
        if (!clr_n)         mode = MODE_CLEAR;
        else if (!strobe_n) mode = MODE_LOAD;
        else if (!step_n)   mode = MODE_STEP;
        else                mode = MODE_KEEP;
    end
endmodule

// File: rtl/bag_select.sv
module bag_select
    import bag_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  bag_mode_e         mode,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] sel
);
    localparam logic [ADDR_W-1:0] TOP_WORD = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] succ;

    // Explicit wrap at the last word of the array.
    always_comb begin
        if (cur == TOP_WORD) succ = '0;
        else                 succ = cur + 1'b1;
    end

    always_comb begin
        unique case (mode)
            MODE_CLEAR: sel = '0;
            MODE_LOAD:  sel = ext_addr;
            MODE_STEP:  sel = succ;
            default:    sel = cur;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] ptr_now
);
    localparam logic [ADDR_W-1:0] TOP_WORD = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } bag_state_t;

    bag_state_t st_d, st_q;
    bag_mode_e  mode;
    logic [ADDR_W-1:0] sel;

    bag_decode u_decode (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clr_n    (clr_n),
        .mode     (mode)
    );

    bag_select #(.ADDR_W(ADDR_W)) u_select (
        .mode     (mode),
        .ext_addr (ext_addr),
        .cur      (st_q.ptr),
        .sel      (sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ptr = sel;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_addr = sel;
    assign ptr_now  = st_q.ptr;

    // R1: reset clears the pointer
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> ptr_now == '0);

    // R2: clear wins over strobe and step
    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> ptr_now == '0);

    // R3: strobe captures the external bus
    assert_load_ext_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !strobe_n) |=> ptr_now == $past(ext_addr));

    // R4 and R6: a step moves one word, wrapping modulo the array
    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_n && strobe_n && !step_n) |=> ptr_now == $past(ptr_now) + 1'b1);

    // R6: the top word steps to zero
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_n && strobe_n && !step_n && ptr_now == TOP_WORD) |=> ptr_now == '0);

    // R5: hold leaves the pointer unchanged
    assert_hold_still_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_n && strobe_n && step_n) |=> $stable(ptr_now));

    // R7: the address used this cycle is where the next cycle resumes
    assert_resume_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ptr_now == $past(acc_addr));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int ADDR_W = 14;
    localparam logic [ADDR_W-1:0] TOPW = {ADDR_W{1'b1}};

    typedef struct {
        logic [ADDR_W-1:0] acc;
        logic [ADDR_W-1:0] ptr;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              strobe_n = 1'b1;
    logic              step_n = 1'b1;
    logic              clr_n = 1'b1;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] ptr_now;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    logic [ADDR_W-1:0] model = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .step_n(step_n), .clr_n(clr_n), .acc_addr(acc_addr), .ptr_now(ptr_now)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of controls and queues the expected result.
    task automatic drive(input logic [ADDR_W-1:0] a, input logic s,
                         input logic e, input logic c, input string req);
        exp_t it;
        @(negedge clk);
        ext_addr = a; strobe_n = s; step_n = e; clr_n = c;
        if (!c)      it.acc = '0;
        else if (!s) it.acc = a;
        else if (!e) it.acc = (model == TOPW) ? '0 : model + 1'b1;
        else         it.acc = model;
        it.ptr = model;
        it.req = req;
        q.push_back(it);
        model = it.acc;
    endtask

    // Monitor: compares the outputs in the middle of each driven cycle.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check({it.req, " acc_addr"}, acc_addr, it.acc);
                check({it.req, " ptr_now"}, ptr_now, it.ptr);
            end
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: a strobe during reset must not reach the pointer
        repeat (3) begin
            @(negedge clk);
            ext_addr = 14'd77; strobe_n = 1'b0;
        end
        @(negedge clk);
        rst = 1'b0; strobe_n = 1'b1; ext_addr = '0;
        #3 check("R1 reset", ptr_now, '0);
        model = '0;

        // R3: a strobe loads, and the step level is ignored
        drive(14'd100, 1'b0, 1'b1, 1'b1, "R3");
        drive(14'd200, 1'b0, 1'b0, 1'b1, "R3");
        // R4/R7: a burst from 200 with a hold in the middle
        drive(14'd9,   1'b1, 1'b0, 1'b1, "R4");
        drive(14'd9,   1'b1, 1'b0, 1'b1, "R7");
        drive(14'd555, 1'b1, 1'b1, 1'b1, "R5");
        drive(14'd666, 1'b1, 1'b1, 1'b1, "R5");
        drive(14'd9,   1'b1, 1'b0, 1'b1, "R7");
        // R2: clear wins over the strobe and the step
        drive(14'd300, 1'b0, 1'b0, 1'b0, "R2");
        drive(14'd300, 1'b1, 1'b1, 1'b0, "R2");
        drive(14'd300, 1'b1, 1'b0, 1'b0, "R2");
        // R7: the step after a clear reaches word 1
        drive(14'd300, 1'b1, 1'b0, 1'b1, "R7");
        drive(14'd300, 1'b1, 1'b0, 1'b1, "R7");
        // R6: wrap at the top word, with a hold before it
        drive(TOPW - 1'b1, 1'b0, 1'b1, 1'b1, "R3");
        drive(14'd1,   1'b1, 1'b0, 1'b1, "R4");
        drive(14'd2,   1'b1, 1'b1, 1'b1, "R5");
        drive(14'd3,   1'b1, 1'b0, 1'b1, "R6");
        drive(14'd4,   1'b1, 1'b0, 1'b1, "R6");
        // Mixed burst
        for (int i = 0; i < 20; i++)
            drive(14'(i * 37), (i % 7) != 0, (i % 3) == 0, (i % 11) != 5, "R7");
        drive('0, 1'b1, 1'b1, 1'b1, "R5");
        repeat (3) @(negedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule